// File: doc/BRIEF.md
# Raw NAND Operation Sequencer

This block turns a single operation request into the bus activity a byte-wide raw NAND flash expects. The operation code, column, page, geometry flags and a chip-size class are captured when the request is accepted. The block then runs an ordered series of phases: a first command, the address bytes, outgoing data, a second command, a wait on the ready/busy line, and incoming data. Each operation uses only the phases it needs. Every latch strobe is built from a programmable number of clock cycles.

The block works out the address bytes itself. Column bytes come first and page bytes follow, lowest byte first. The number of address bytes is set by the page-size flag and the size class. Outgoing program data is fetched from a host buffer through an index output and a byte input. Each incoming byte is presented with a one-cycle valid strobe. When the operation ends, a one-cycle done pulse is raised and the block returns to idle.

Operation codes: 0 read, 1 read-spare, 2 random-out, 3 program, 4 erase, 5 read-ID, 6 status, 7 reset. Size class: 0 smallest, 1 middle, 2 or 3 largest.

Top module: `nand_seq`

## Requirements
- R1: After reset, idle is 1, done is 0, both strobes are high, and the command latch (cle) and address latch (ale) are low.
- R2: On small-page parts, read, read-spare and program send one column byte plus page bytes, for 2/3/4 address bytes total in classes 0/1/2. Erase sends 1/2/3 page bytes.
- R3: On large-page parts, read, read-spare and program send two column bytes plus page bytes, for 3/4/5 address bytes total in classes 0/1/2. Erase sends 1/2/3 page bytes.
- R4: The column is sent lowest byte first. On large pages the second column byte carries column bits 11:8 with its top nibble zero. Page bytes follow, lowest first.
- R5: On a 16-bit bus, the column of read, read-spare, random-out and program is halved before it is sent. The read-ID address byte is never halved.
- R6: A large-page read sends 0x00, the address, then 0x30, waits for ready, and then reads len bytes. A small-page read sends only 0x00 and the address before the wait. cle and ale are never high together.
- R7: Program sends 0x80, the address, then len bytes. Byte i is taken from the host buffer while byte_idx equals i. Program then sends 0x10 and waits for ready.
- R8: Erase sends 0x60, the page bytes only, then 0xD0, and waits for ready. It has no data phase.
- R9: Status sends 0x70 with no address and reads exactly one byte. Reset sends 0xFF with no address and no data, then waits for ready.
- R10: Read-ID sends 0x90, then one address byte equal to column[7:0], then reads 8 bytes.
- R11: No read strobe starts and no done pulse is given while ready/busy is low. Done lasts one cycle.
- R12: Every we_n and re_n low phase lasts pulse_cycles clocks, or 1 clock when pulse_cycles is 0. The two strobes are never low together.
- R13: A request that arrives while the block is not idle is ignored and produces no bus activity.
- R14: Read-spare on large pages sends 0x00, a column of 2048 plus the offset, then 0x30. On small pages it sends 0x50 and no second command. Random-out sends 0x05 and the column bytes only. On large pages it adds 0xE0. It never waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only while idle |
| op | input | 3 | Operation code |
| column | input | 12 | Column byte address |
| page | input | 24 | Page address |
| large_page | input | 1 | 1 for large-page parts |
| bus16 | input | 1 | 1 for a 16-bit flash bus |
| size_class | input | 2 | Chip-size class |
| xfer_len | input | 8 | Byte count for read, read-spare, random-out and program |
| pulse_cycles | input | 4 | Strobe low/high phase length in clocks |
| idle | output | 1 | Ready for a request |
| done | output | 1 | One-cycle completion pulse |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Byte driven onto the flash bus |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Byte from the flash bus |
| rb_n | input | 1 | Ready (1) / busy (0) from the flash |
| byte_idx | output | 8 | Index of the current data byte |
| wr_byte | input | 8 | Host buffer byte at byte_idx |
| rd_valid | output | 1 | rd_data holds a newly read byte |
| rd_data | output | 8 | Byte read from the flash |

## Verification
The hardest case to reach is a read that must hold back its first read strobe while the flash stays busy for much longer than the block's fixed guard delay. The bench's flash model pulls ready/busy low when it sees a busy-making command latched. For small-page reads, it does this after the final address byte instead. The model then holds the line low for tens of cycles. A scoreboard compares every latched command, address and data byte against a queue built from the requirements. Separate counts catch any read strobe that starts during busy and any request that arrives mid-operation and is wrongly accepted.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int LEN_W       = 8,
  parameter int LARGE_SPARE = 2048,
  parameter int GUARD       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       op,
  input  logic [11:0]      column,
  input  logic [23:0]      page,
  input  logic             large_page,
  input  logic             bus16,
  input  logic [1:0]       size_class,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [3:0]       pulse_cycles,
  output logic             idle,
  output logic             done,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n,
  output logic [LEN_W-1:0] byte_idx,
  input  logic [7:0]       wr_byte,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  localparam logic [2:0] OP_RD = 3'd0, OP_SP = 3'd1, OP_RO = 3'd2, OP_PG = 3'd3,
                         OP_ER = 3'd4, OP_ID = 3'd5, OP_ST = 3'd6, OP_RS = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT, S_RDATA, S_DONE} st_t;

  st_t              st, nxt;
  logic [2:0]       op_q;
  logic [11:0]      col_q;
  logic [23:0]      page_q;
  logic             large_q;
  logic [1:0]       cls_q;
  logic [LEN_W-1:0] len_q, idx, reps, rlen, wlen;
  logic [3:0]       tp, cnt;
  logic             hi;
  logic [2:0]       pbytes, n_addr;
  logic [7:0]       cmd1, cmd2;
  logic             has_cmd2, waits;
  logic [7:0]       ab [5];
  logic [7:0]       en;
  logic [11:0]      base;

  always_comb begin
    base = (op == OP_SP && large_page) ? column + 12'(LARGE_SPARE) : column;
    if (bus16 && (op == OP_RD || op == OP_SP || op == OP_RO || op == OP_PG))
      base = base >> 1;
  end

  assign pbytes = (cls_q == 2'd0) ? 3'd1 : (cls_q == 2'd1) ? 3'd2 : 3'd3;

  always_comb begin
    cmd1 = 8'h00; cmd2 = 8'h00; has_cmd2 = 1'b0; waits = 1'b0; n_addr = 3'd0;
    rlen = '0; wlen = '0;
    for (int i = 0; i < 5; i++) ab[i] = 8'h00;
    if (large_q) begin
      ab[0] = col_q[7:0]; ab[1] = {4'h0, col_q[11:8]};
      ab[2] = page_q[7:0]; ab[3] = page_q[15:8]; ab[4] = page_q[23:16];
    end else begin
      ab[0] = col_q[7:0];
      ab[1] = page_q[7:0]; ab[2] = page_q[15:8]; ab[3] = page_q[23:16];
    end
    case (op_q)
      OP_RD, OP_SP: begin
        cmd1 = (op_q == OP_SP && !large_q) ? 8'h50 : 8'h00;
        cmd2 = 8'h30; has_cmd2 = large_q; waits = 1'b1;
        n_addr = pbytes + (large_q ? 3'd2 : 3'd1); rlen = len_q;
      end
      OP_RO: begin
        cmd1 = 8'h05; cmd2 = 8'hE0; has_cmd2 = large_q;
        n_addr = large_q ? 3'd2 : 3'd1; rlen = len_q;
      end
      OP_PG: begin
        cmd1 = 8'h80; cmd2 = 8'h10; has_cmd2 = 1'b1; waits = 1'b1;
        n_addr = pbytes + (large_q ? 3'd2 : 3'd1); wlen = len_q;
      end
      OP_ER: begin
        cmd1 = 8'h60; cmd2 = 8'hD0; has_cmd2 = 1'b1; waits = 1'b1; n_addr = pbytes;
        ab[0] = page_q[7:0]; ab[1] = page_q[15:8]; ab[2] = page_q[23:16];
      end
      OP_ID: begin
        cmd1 = 8'h90; n_addr = 3'd1; rlen = LEN_W'(8); ab[0] = col_q[7:0];
      end
      OP_ST: begin cmd1 = 8'h70; rlen = LEN_W'(1); end
      default: begin cmd1 = 8'hFF; waits = 1'b1; end
    endcase
  end

  always_comb begin
    en = '0;
    en[S_CMD1]  = 1'b1;
    en[S_ADDR]  = n_addr != 3'd0;
    en[S_WDATA] = wlen != '0;
    en[S_CMD2]  = has_cmd2;
    en[S_WAIT]  = waits;
    en[S_RDATA] = rlen != '0;
    en[S_DONE]  = 1'b1;
    nxt = S_DONE;
    for (int s = 7; s >= 1; s--)
      if (3'(s) > st && en[s]) nxt = st_t'(3'(s));
  end

  always_comb
    case (st)
      S_ADDR:  reps = LEN_W'(n_addr);
      S_WDATA: reps = wlen;
      S_RDATA: reps = rlen;
      default: reps = LEN_W'(1);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; col_q <= '0; page_q <= '0; large_q <= 1'b0;
      cls_q <= '0; len_q <= '0; tp <= 4'd1; cnt <= '0; hi <= 1'b0; idx <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          op_q <= op; col_q <= base; page_q <= page; large_q <= large_page;
          cls_q <= size_class; len_q <= xfer_len;
          tp <= (pulse_cycles == 4'd0) ? 4'd1 : pulse_cycles;
          cnt <= '0; hi <= 1'b0; idx <= '0; st <= S_CMD1;
        end
        S_WAIT:
          if (cnt != 4'(GUARD)) cnt <= cnt + 4'd1;
          else if (rb_n) begin cnt <= '0; st <= nxt; end
        S_DONE: st <= S_IDLE;
        default:
          if (cnt == tp - 4'd1) begin
            cnt <= '0;
            if (!hi) begin
              hi <= 1'b1;
              if (st == S_RDATA) begin rd_valid <= 1'b1; rd_data <= io_in; end
            end else begin
              hi <= 1'b0;
              if (idx == reps - 1'b1) begin idx <= '0; st <= nxt; end
              else idx <= idx + 1'b1;
            end
          end else cnt <= cnt + 4'd1;
      endcase
    end

  assign idle     = st == S_IDLE;
  assign done     = st == S_DONE;
  assign cle      = st == S_CMD1 || st == S_CMD2;
  assign ale      = st == S_ADDR;
  assign io_oe    = cle || ale || st == S_WDATA;
  assign we_n     = !(io_oe && !hi);
  assign re_n     = !(st == S_RDATA && !hi);
  assign byte_idx = idx;
  assign io_out   = (st == S_CMD1) ? cmd1 : (st == S_CMD2) ? cmd2 :
                    (st == S_ADDR) ? ab[idx[2:0]] : (st == S_WDATA) ? wr_byte : 8'h00;

  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  p_re_ready_r11: assert property (@(posedge clk) disable iff (!rst_n) $fell(re_n) |-> rb_n);
  p_done_ready_r11: assert property (@(posedge clk) disable iff (!rst_n) done |-> rb_n);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n) !idle |=> $stable(op_q) && $stable(page_q));
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] op = '0;
  logic [11:0] column = '0;
  logic [23:0] page = '0;
  logic large_page = 1'b0, bus16 = 1'b0;
  logic [1:0] size_class = '0;
  logic [7:0] xfer_len = '0;
  logic [3:0] pulse_cycles = 4'd2;
  logic idle, done, cle, ale, we_n, re_n, io_oe, rb_n, rd_valid;
  logic [7:0] io_out, io_in, byte_idx, wr_byte, rd_data;

  int total = 0, bad = 0, cycles = 0;
  logic [9:0] exp_q[$];
  string req_q[$];
  int rcount = 0, busy_cnt = 0, addr_seen = 0, trig_addr = 0, cur_t = 2;
  int we_low = 0, re_low = 0, bad_re = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always #4 clk = ~clk;

  assign rb_n    = busy_cnt == 0;
  assign io_in   = 8'(8'h3C + 7 * rcount);
  assign wr_byte = 8'h5A ^ 8'(byte_idx * 3);

  nand_seq uut (.clk(clk), .rst_n(rst_n), .req(req), .op(op), .column(column), .page(page),
    .large_page(large_page), .bus16(bus16), .size_class(size_class), .xfer_len(xfer_len),
    .pulse_cycles(pulse_cycles), .idle(idle), .done(done), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n),
    .byte_idx(byte_idx), .wr_byte(wr_byte), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b, input string r);
    exp_q.push_back({k, b});
    req_q.push_back(r);
  endtask

  task automatic pop_cmp(input logic [9:0] got);
    if (exp_q.size() == 0) check(1'b0, "R13 unexpected bus item", int'(got), 0);
    else begin
      logic [9:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(got == e, r, int'(got), int'(e));
    end
  endtask

  int busy_len = 0;
  always @(negedge clk) begin
    cycles++;
    if (busy_cnt > 0) busy_cnt--;
    if (!we_n) we_low++;
    if (!re_n) re_low++;
    if (!re_n && prev_re && !rb_n) bad_re++;
    if (we_n && !prev_we) begin
      pop_cmp({cle ? 2'd1 : (ale ? 2'd2 : 2'd3), io_out});
      check(we_low == cur_t, "R12 we_n low width", we_low, cur_t);
      if (cle && (io_out == 8'h30 || io_out == 8'h10 || io_out == 8'hD0 || io_out == 8'hFF))
        busy_cnt = busy_len;
      if (ale) begin
        addr_seen++;
        if (addr_seen == trig_addr) busy_cnt = busy_len;
      end
      we_low = 0;
    end
    if (re_n && !prev_re) begin
      check(re_low == cur_t, "R12 re_n low width", re_low, cur_t);
      re_low = 0;
      rcount++;
    end
    if (rd_valid) pop_cmp({2'd0, rd_data});
    if (done) check(rb_n == 1'b1, "R11 done while busy", int'(rb_n), 1);
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic run_op(input logic [2:0] o, input logic [11:0] c, input logic [23:0] p,
                        input bit lg, input bit b16, input logic [1:0] cls, input logic [7:0] len,
                        input logic [3:0] t, input int busy, input string tag, input bit poke);
    int pbn;
    logic [12:0] ce;
    logic [7:0] c1;
    int nrd;
    pbn = (cls == 0) ? 1 : (cls == 1) ? 2 : 3;
    ce = (o == 3'd1 && lg) ? 13'd2048 + {1'b0, c} : {1'b0, c};
    if (b16 && o <= 3'd3) ce = ce >> 1;
    case (o)
      3'd0: c1 = 8'h00;
      3'd1: c1 = lg ? 8'h00 : 8'h50;
      3'd2: c1 = 8'h05;
      3'd3: c1 = 8'h80;
      3'd4: c1 = 8'h60;
      3'd5: c1 = 8'h90;
      3'd6: c1 = 8'h70;
      default: c1 = 8'hFF;
    endcase
    push(2'd1, c1, {tag, " first command"});
    if (o == 3'd4)
      for (int i = 0; i < pbn; i++) push(2'd2, p[8*i +: 8], {tag, " erase page byte"});
    else if (o == 3'd5) push(2'd2, c[7:0], {tag, " id address"});
    else if (o <= 3'd3) begin
      push(2'd2, ce[7:0], {tag, " column low"});
      if (lg) push(2'd2, {4'h0, ce[11:8]}, {tag, " column high"});
      if (o != 3'd2)
        for (int i = 0; i < pbn; i++) push(2'd2, p[8*i +: 8], {tag, " page byte"});
    end
    if (o == 3'd3)
      for (int i = 0; i < len; i++) push(2'd3, 8'h5A ^ 8'(i * 3), {tag, " program data"});
    if (o == 3'd3) push(2'd1, 8'h10, {tag, " confirm"});
    if (o == 3'd4) push(2'd1, 8'hD0, {tag, " confirm"});
    if (lg && o <= 3'd1) push(2'd1, 8'h30, {tag, " confirm"});
    if (lg && o == 3'd2) push(2'd1, 8'hE0, {tag, " confirm"});
    nrd = (o == 3'd5) ? 8 : (o == 3'd6) ? 1 : (o <= 3'd2) ? int'(len) : 0;
    for (int k = 0; k < nrd; k++) push(2'd0, 8'(8'h3C + 7 * k), {tag, " read data"});

    @(negedge clk);
    rcount = 0; addr_seen = 0; busy_len = busy;
    trig_addr = (!lg && o <= 3'd1) ? 1 + pbn : 0;
    cur_t = (t == 0) ? 1 : int'(t);
    op = o; column = c; page = p; large_page = lg; bus16 = b16; size_class = cls;
    xfer_len = len; pulse_cycles = t; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(idle == 1'b0, "R13 busy while operating", int'(idle), 0);
      op = 3'd7; page = 24'hFFFFFF; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done && cycles < 150000) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " sequence complete"}, exp_q.size(), 0);
    check(idle == 1'b1, {tag, " back to idle"}, int'(idle), 1);
    exp_q.delete();
    req_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idle && !done && we_n && re_n && !cle && !ale, "R1 reset state",
          {idle, done, we_n, re_n, cle, ale}, 6'b101100);
    rst_n = 1'b1;
    run_op(3'd0, 12'h123, 24'h0A0B0C, 1, 0, 2'd2, 8'd4, 4'd2, 40, "R3 R4 R6 large read", 0);
    run_op(3'd0, 12'h045, 24'h112233, 0, 0, 2'd2, 8'd3, 4'd2, 35, "R2 R6 small read", 0);
    run_op(3'd0, 12'h010, 24'h000077, 0, 0, 2'd0, 8'd1, 4'd1, 20, "R2 small read class0", 0);
    run_op(3'd0, 12'h246, 24'h00ABCD, 1, 1, 2'd1, 8'd2, 4'd2, 25, "R5 bus16 read", 0);
    run_op(3'd3, 12'h000, 24'h000042, 1, 0, 2'd0, 8'd5, 4'd3, 30, "R7 R3 program", 0);
    run_op(3'd3, 12'h082, 24'h000042, 0, 1, 2'd1, 8'd2, 4'd2, 10, "R7 R5 small bus16 program", 0);
    run_op(3'd4, 12'h000, 24'h00C1C2, 0, 0, 2'd1, 8'd0, 4'd2, 30, "R8 R2 small erase", 0);
    run_op(3'd4, 12'h000, 24'hE1E2E3, 1, 0, 2'd2, 8'd0, 4'd2, 60, "R8 R13 large erase", 1);
    run_op(3'd5, 12'h020, 24'h000000, 1, 1, 2'd2, 8'd0, 4'd2, 0, "R10 R5 read id", 0);
    run_op(3'd6, 12'h000, 24'h000000, 1, 0, 2'd2, 8'd0, 4'd2, 0, "R9 status", 0);
    run_op(3'd7, 12'h000, 24'h000000, 1, 0, 2'd2, 8'd0, 4'd0, 25, "R9 R12 reset", 0);
    run_op(3'd1, 12'h004, 24'h000305, 1, 0, 2'd1, 8'd2, 4'd2, 30, "R14 large spare", 0);
    run_op(3'd1, 12'h003, 24'h000909, 0, 0, 2'd1, 8'd2, 4'd2, 30, "R14 small spare", 0);
    run_op(3'd2, 12'h010, 24'h000000, 1, 0, 2'd2, 8'd2, 4'd2, 0, "R14 large random out", 0);
    run_op(3'd2, 12'h007, 24'h000000, 0, 0, 2'd2, 8'd1, 4'd2, 0, "R14 small random out", 0);
    check(bad_re == 0, "R11 read strobe during busy", bad_re, 0);
    if (cycles >= 150000) check(1'b0, "watchdog expired", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule